// File: doc/BRIEF.md
# Flash status polling controller

This block sits on the host side of a parallel NOR flash. The host has already written a program or erase command sequence to the flash. The block then waits until that operation is finished. A start pulse tells it the operation type, the target address and the expected data word. The block counts the command write strobes the host still has to issue. Once the last strobe required for that operation has passed, it starts reading status from the target address through a request/acknowledge read port.

Three completion methods are available. The first watches the inverted bit 7 of the read data. The second compares bit 6 across consecutive reads. The third waits for the ready/busy pin alone. Once completion is seen, the controller waits a programmable settle interval worth one microsecond of clock cycles. It then performs a single verification read and reports one of four results: success, erase-suspended sector, timeout, or verification failure. A cycle counter bounds the polling phase so that a dead flash cannot hang the host.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o` and `rd_req_o` are low.
- R2: No read is requested until, after the start pulse, `cmd_strobe_i` has been seen high 4 times for a program (`op_erase_i`=0) or 6 times for an erase (`op_erase_i`=1).
- R3: Every read is issued to the address captured at start, and `rd_addr_o` stays constant while the block is busy.
- R4: With `mode_i`=0 (data polling), a program is complete when read bit 7 equals bit 7 of the expected data, and an erase is complete when read bit 7 is 1. Until then the block keeps reading.
- R5: With `mode_i`=1 (toggle), the block compares bit 6 of each read with bit 6 of the previous read. A difference means busy and the block reads again. Equality means complete.
- R6: In toggle mode, if bit 6 is 1 in both reads of a pair and bit 2 differs between them, the block finishes with status 1 (suspended) and does not perform a verification read.
- R7: With `mode_i`=2 or 3 (ready pin), no read is issued while `ready_i` is low. Completion is taken from `ready_i` going high.
- R8: Between the last polling event and the verification read, the read request stays low for at least SETTLE_CYC cycles, where SETTLE_CYC is the ceiling of CLK_MHZ·SETTLE_NS/1000.
- R9: After the settle wait, exactly one verification read is made. For a program, a mismatch with the expected data gives status 3 and a match gives status 0. For an erase, the result is status 0 (the default configuration does not compare erase data).
- R10: If completion is not seen within TIMEOUT_CYC polling cycles, the block abandons polling, withdraws any pending request and finishes with status 2.
- R11: `done_o` is a one-cycle pulse in a cycle where `busy_o` is low. `status_o` changes only together with `done_o`. `busy_o` rises the cycle after an accepted start. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| op_erase_i | input | 1 | Operation type: 0 program, 1 erase |
| mode_i | input | 2 | Completion method: 0 data polling, 1 toggle, 2/3 ready pin |
| addr_i | input | AW | Target address inside the sector being operated on |
| exp_data_i | input | DW | Data expected after a program |
| cmd_strobe_i | input | 1 | One-cycle pulse per command write strobe completed by the host |
| ready_i | input | 1 | Ready/busy pin, low means busy (synchronous to clk) |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid in the same cycle |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Operation being tracked |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Result: 0 ok, 1 suspended, 2 timeout, 3 verify failure |

## Verification
The bound checker checks several rules on every cycle. These are the strobe gate before any read, the constant read address during an operation, the settle gap before the verification read, and the single-cycle, idle-qualified completion pulse with a status that only moves with it. The bench's scenarios are needed for the rest. They show which result each polling method reaches for a given flash response: inverted bit 7 for program and erase, toggling and suspended bit patterns, the ready pin held low or released late, and a verification mismatch. They also show that a start pulse during an operation leaves no trace.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

   typedef enum logic [1:0] {
      PM_DATA      = 2'd0,
      PM_TOGGLE    = 2'd1,
      PM_READY     = 2'd2,
      PM_READY_ALT = 2'd3
   } poll_mode_e;

   typedef enum logic [1:0] {
      RS_OK          = 2'd0,
      RS_SUSPENDED   = 2'd1,
      RS_TIMEOUT     = 2'd2,
      RS_VERIFY_FAIL = 2'd3
   } result_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_STROBE,
      S_READ,
      S_EVAL,
      S_WAIT_RDY,
      S_SETTLE,
      S_VERIFY,
      S_VCHECK
   } poll_state_e;

   // status bit positions decoded from a flash read
   localparam int BIT_INV = 7;
   localparam int BIT_TOG = 6;
   localparam int BIT_SUS = 2;

endpackage

// File: rtl/fpc_timer.sv
module fpc_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (run && cnt_q != LIM)
         cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == LIM);

endmodule

// File: rtl/fpc_status_eval.sv
module fpc_status_eval
   import flash_poll_pkg::*;
#(
   parameter int DW           = 16,
   parameter bit VERIFY_ERASE = 1'b0
) (
   input  logic          op_erase,
   input  logic [DW-1:0] exp_data,
   input  logic [DW-1:0] cur_data,
   input  logic          prev_tog,
   input  logic          prev_sus,
   output logic          poll_done,
   output logic          tog_busy,
   output logic          tog_susp,
   output logic          verify_bad
);
   assign poll_done = op_erase ? cur_data[BIT_INV]
                               : (cur_data[BIT_INV] == exp_data[BIT_INV]);
   assign tog_busy  = cur_data[BIT_TOG] ^ prev_tog;
   assign tog_susp  = !tog_busy && cur_data[BIT_TOG] && (cur_data[BIT_SUS] ^ prev_sus);

   generate
      if (VERIFY_ERASE) begin : g_erase_cmp
         assign verify_bad = op_erase ? (cur_data != {DW{1'b1}})
                                      : (cur_data != exp_data);
      end else begin : g_prog_cmp
         assign verify_bad = !op_erase && (cur_data != exp_data);
      end
   endgenerate

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
   import flash_poll_pkg::*;
#(
   parameter int AW            = 20,
   parameter int DW            = 16,
   parameter int CLK_MHZ       = 50,
   parameter int SETTLE_NS     = 1000,
   parameter int TIMEOUT_CYC   = 100000,
   parameter int PROG_STROBES  = 4,
   parameter int ERASE_STROBES = 6,
   parameter bit VERIFY_ERASE  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          op_erase_i,
   input  logic [1:0]    mode_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] exp_data_i,
   input  logic          cmd_strobe_i,
   input  logic          ready_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_ack_i,
   input  logic [DW-1:0] rd_data_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [1:0]    status_o
);
   localparam int SETTLE_CYC = (CLK_MHZ * SETTLE_NS + 999) / 1000;
   localparam int MAX_STB    = (PROG_STROBES > ERASE_STROBES) ? PROG_STROBES : ERASE_STROBES;
   localparam int STB_W      = $clog2(MAX_STB + 1);
   localparam logic [STB_W-1:0] PROG_N  = STB_W'(PROG_STROBES);
   localparam logic [STB_W-1:0] ERASE_N = STB_W'(ERASE_STROBES);

   generate
      if (DW < 8) begin : g_chk_dw
         $error("flash_poll_ctrl: DW must cover status bit 7");
      end
      if (AW < 1) begin : g_chk_aw
         $error("flash_poll_ctrl: AW must be positive");
      end
      if (PROG_STROBES < 1 || ERASE_STROBES < 1) begin : g_chk_stb
         $error("flash_poll_ctrl: strobe counts must be positive");
      end
      if (SETTLE_CYC < 1 || TIMEOUT_CYC < 1) begin : g_chk_time
         $error("flash_poll_ctrl: settle and timeout must be at least one cycle");
      end
   endgenerate

   poll_state_e   st_q;
   poll_mode_e    mode_q;
   logic          erase_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] exp_q;
   logic [DW-1:0] rd_q;
   logic [STB_W-1:0] stb_q;
   logic [1:0]    prev_q;      // {bit 6, bit 2} of the previous read
   logic          have_prev_q;
   logic          done_q;
   result_e       status_q;

   logic [STB_W-1:0] need_stb, stb_nxt;
   logic polling, tmo_exp, settle_exp;
   logic poll_done, tog_busy, tog_susp, verify_bad;
   logic verify_phase;

   assign need_stb = erase_q ? ERASE_N : PROG_N;
   assign stb_nxt  = stb_q + 1'b1;
   assign polling  = (st_q == S_READ) || (st_q == S_EVAL) || (st_q == S_WAIT_RDY);

   fpc_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (st_q == S_STROBE),
      .run     (polling),
      .expired (tmo_exp)
   );

   fpc_timer #(.LIMIT(SETTLE_CYC)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (st_q != S_SETTLE),
      .run     (st_q == S_SETTLE),
      .expired (settle_exp)
   );

   fpc_status_eval #(.DW(DW), .VERIFY_ERASE(VERIFY_ERASE)) u_eval (
      .op_erase   (erase_q),
      .exp_data   (exp_q),
      .cur_data   (rd_q),
      .prev_tog   (prev_q[1]),
      .prev_sus   (prev_q[0]),
      .poll_done  (poll_done),
      .tog_busy   (tog_busy),
      .tog_susp   (tog_susp),
      .verify_bad (verify_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         mode_q      <= PM_DATA;
         erase_q     <= 1'b0;
         addr_q      <= '0;
         exp_q       <= '0;
         rd_q        <= '0;
         stb_q       <= '0;
         prev_q      <= '0;
         have_prev_q <= 1'b0;
         done_q      <= 1'b0;
         status_q    <= RS_OK;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (start_i) begin
                  erase_q     <= op_erase_i;
                  mode_q      <= poll_mode_e'(mode_i);
                  addr_q      <= addr_i;
                  exp_q       <= exp_data_i;
                  stb_q       <= '0;
                  have_prev_q <= 1'b0;
                  st_q        <= S_STROBE;
               end
            end
            S_STROBE: begin
               if (cmd_strobe_i) begin
                  stb_q <= stb_nxt;
                  if (stb_nxt == need_stb)
                     st_q <= (mode_q == PM_READY || mode_q == PM_READY_ALT) ? S_WAIT_RDY : S_READ;
               end
            end
            S_READ: begin
               if (tmo_exp) begin
                  st_q     <= S_IDLE;
                  done_q   <= 1'b1;
                  status_q <= RS_TIMEOUT;
               end else if (rd_ack_i) begin
                  rd_q <= rd_data_i;
                  st_q <= S_EVAL;
               end
            end
            S_EVAL: begin
               if (mode_q == PM_TOGGLE) begin
                  prev_q      <= {rd_q[BIT_TOG], rd_q[BIT_SUS]};
                  have_prev_q <= 1'b1;
                  if (!have_prev_q || tog_busy)
                     st_q <= S_READ;
                  else if (tog_susp) begin
                     st_q     <= S_IDLE;
                     done_q   <= 1'b1;
                     status_q <= RS_SUSPENDED;
                  end else
                     st_q <= S_SETTLE;
               end else begin
                  st_q <= poll_done ? S_SETTLE : S_READ;
               end
            end
            S_WAIT_RDY: begin
               if (tmo_exp) begin
                  st_q     <= S_IDLE;
                  done_q   <= 1'b1;
                  status_q <= RS_TIMEOUT;
               end else if (ready_i)
                  st_q <= S_SETTLE;
            end
            S_SETTLE: begin
               if (settle_exp)
                  st_q <= S_VERIFY;
            end
            S_VERIFY: begin
               if (rd_ack_i) begin
                  rd_q <= rd_data_i;
                  st_q <= S_VCHECK;
               end
            end
            S_VCHECK: begin
               st_q     <= S_IDLE;
               done_q   <= 1'b1;
               status_q <= verify_bad ? RS_VERIFY_FAIL : RS_OK;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign verify_phase = (st_q == S_VERIFY);
   assign rd_req_o     = (st_q == S_READ) || verify_phase;
   assign rd_addr_o    = addr_q;
   assign busy_o       = (st_q != S_IDLE);
   assign done_o       = done_q;
   assign status_o     = status_q;

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
   parameter int AW            = 20,
   parameter int PROG_STROBES  = 4,
   parameter int ERASE_STROBES = 6,
   parameter int SETTLE_CYC    = 50
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          op_erase_i,
   input logic          cmd_strobe_i,
   input logic          rd_req_o,
   input logic [AW-1:0] rd_addr_o,
   input logic          busy_o,
   input logic          done_o,
   input logic [1:0]    status_o,
   input logic          verify_phase
);
   logic [7:0]  stb_seen;
   logic [7:0]  need_q;
   logic [15:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_seen <= '0;
         need_q   <= '0;
         low_cnt  <= '0;
      end else begin
         if (start_i && !busy_o) begin
            stb_seen <= '0;
            need_q   <= op_erase_i ? 8'(ERASE_STROBES) : 8'(PROG_STROBES);
         end else if (cmd_strobe_i && stb_seen != 8'hFF)
            stb_seen <= stb_seen + 1'b1;
         if (rd_req_o)
            low_cnt <= '0;
         else if (low_cnt != 16'hFFFF)
            low_cnt <= low_cnt + 1'b1;
      end
   end

   assert_strobe_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> stb_seen >= need_q);

   assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> $stable(rd_addr_o));

   assert_settle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      verify_phase && rd_req_o && !$past(rd_req_o) |-> low_cnt >= 16'(SETTLE_CYC));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(status_o));

   assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o);

endmodule

bind flash_poll_ctrl fpc_checker #(
   .AW            (AW),
   .PROG_STROBES  (PROG_STROBES),
   .ERASE_STROBES (ERASE_STROBES),
   .SETTLE_CYC    (SETTLE_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .op_erase_i   (op_erase_i),
   .cmd_strobe_i (cmd_strobe_i),
   .rd_req_o     (rd_req_o),
   .rd_addr_o    (rd_addr_o),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .status_o     (status_o),
   .verify_phase (verify_phase)
);

// File: tb/flash_poll_ctrl_test.sv
module flash_poll_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW         = 12;
   localparam int DW         = 8;
   localparam int CLK_MHZ    = 10;
   localparam int SETTLE_NS  = 1000;
   localparam int SETTLE_CYC = 10;
   localparam int TMO        = 300;

   localparam logic [1:0] ST_OK = 2'd0, ST_SUSP = 2'd1, ST_TMO = 2'd2, ST_VFAIL = 2'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          op_erase_i = 1'b0;
   logic [1:0]    mode_i = 2'd0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] exp_data_i = '0;
   logic          cmd_strobe_i = 1'b0;
   logic          ready_i = 1'b1;
   logic          rd_req_o;
   logic [AW-1:0] rd_addr_o;
   logic          rd_ack_i = 1'b0;
   logic [DW-1:0] rd_data_i = '0;
   logic          busy_o, done_o;
   logic [1:0]    status_o;

   flash_poll_ctrl #(
      .AW(AW), .DW(DW), .CLK_MHZ(CLK_MHZ), .SETTLE_NS(SETTLE_NS), .TIMEOUT_CYC(TMO)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
      .mode_i(mode_i), .addr_i(addr_i), .exp_data_i(exp_data_i),
      .cmd_strobe_i(cmd_strobe_i), .ready_i(ready_i), .rd_req_o(rd_req_o),
      .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
      .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0, n_bad = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   typedef struct { logic [1:0] st; string tag; } exp_t;
   exp_t sb_q[$];

   // flash model state
   int         m_busy = 0;
   bit         m_erase = 0, m_susp = 0, tog6 = 0, tog2 = 0;
   logic [7:0] m_true = '0;

   always @(negedge clk) begin
      if (rd_req_o && !rd_ack_i) begin
         rd_ack_i <= 1'b1;
         if (m_susp) begin
            rd_data_i <= 8'h40 | (8'(tog2) << 2);
            tog2 = ~tog2;
         end else if (m_busy > 0) begin
            m_busy--;
            rd_data_i <= {(m_erase ? 1'b0 : ~m_true[7]), tog6, 6'h15};
            tog6 = ~tog6;
         end else
            rd_data_i <= m_true;
      end else
         rd_ack_i <= 1'b0;
   end

   // monitor / scoreboard
   int            low_run = 0, last_gap = 0, strobes_sent = 0, need_now = 0;
   bit            prev_req = 0, addr_bad = 0, early_bad = 0, rdy_bad = 0, rdy_mode = 0, op_done = 0;
   logic [AW-1:0] cur_addr = '0;
   exp_t          e;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_req_o && !prev_req) last_gap = low_run;
         if (rd_req_o) low_run = 0; else low_run++;
         prev_req = rd_req_o;
         if (rd_req_o && rd_addr_o != cur_addr) addr_bad = 1;
         if (rd_req_o && strobes_sent < need_now) early_bad = 1;
         if (rd_req_o && rdy_mode && !ready_i) rdy_bad = 1;
         if (done_o) begin
            if (sb_q.size() == 0)
               chk(1'b0, "R11 unexpected done", int'(status_o), 0);
            else begin
               e = sb_q.pop_front();
               chk(status_o == e.st, e.tag, int'(status_o), int'(e.st));
            end
            op_done = 1;
         end
      end
   end

   task automatic run_op(input bit erase, input logic [1:0] mode, input logic [AW-1:0] addr,
                         input logic [7:0] expd, input logic [7:0] truev, input int busy,
                         input bit susp, input int rdy_delay, input bit restart,
                         input logic [1:0] want, input string tag);
      exp_t it;
      m_erase = erase; m_busy = busy; m_susp = susp; m_true = truev; tog6 = 0; tog2 = 0;
      cur_addr = addr; need_now = erase ? 6 : 4; strobes_sent = 0;
      addr_bad = 0; early_bad = 0; rdy_bad = 0; op_done = 0;
      rdy_mode = (mode >= 2'd2);
      ready_i = rdy_mode ? 1'b0 : 1'b1;
      it.st = want; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      start_i = 1; op_erase_i = erase; mode_i = mode; addr_i = addr; exp_data_i = expd;
      @(negedge clk);
      start_i = 0; addr_i = ~addr; exp_data_i = ~expd;
      chk(busy_o == 1'b1, "R11 busy after start", int'(busy_o), 1);
      repeat (2) @(negedge clk);
      for (int i = 0; i < need_now; i++) begin
         cmd_strobe_i = 1; strobes_sent++;
         @(negedge clk);
         cmd_strobe_i = 0;
         if (restart && i == 0) begin
            start_i = 1; addr_i = addr ^ 12'h1; op_erase_i = ~erase;
            @(negedge clk);
            start_i = 0;
         end
         repeat (3) @(negedge clk);
      end
      if (rdy_mode && rdy_delay >= 0) begin
         repeat (rdy_delay) @(negedge clk);
         ready_i = 1;
      end
      while (!op_done) @(negedge clk);
      chk(!addr_bad, "R3 read address", int'(addr_bad), 0);
      chk(!early_bad, "R2 read before last strobe", int'(early_bad), 0);
      if (rdy_mode) chk(!rdy_bad, "R7 read while ready low", int'(rdy_bad), 0);
      if (want == ST_OK || want == ST_VFAIL)
         chk(last_gap >= SETTLE_CYC, "R8 settle gap", last_gap, SETTLE_CYC);
      ready_i = 1;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(busy_o == 0, "R1 busy after reset", int'(busy_o), 0);
      chk(done_o == 0, "R1 done after reset", int'(done_o), 0);
      chk(rd_req_o == 0, "R1 request after reset", int'(rd_req_o), 0);

      run_op(0, 2'd0, 12'h123, 8'hA5, 8'hA5, 3,    0, 0,  0, ST_OK,    "R4 program data poll");
      run_op(1, 2'd0, 12'h456, 8'h00, 8'hFF, 4,    0, 0,  0, ST_OK,    "R4 erase data poll");
      run_op(0, 2'd0, 12'h0F0, 8'h12, 8'h12, 3,    0, 0,  0, ST_OK,    "R4 program bit7 zero");
      run_op(0, 2'd1, 12'h789, 8'h3C, 8'h3C, 5,    0, 0,  1, ST_OK,    "R5 program toggle, R11 restart ignored");
      run_op(1, 2'd1, 12'h2A0, 8'h00, 8'hFF, 3,    0, 0,  0, ST_OK,    "R5 erase toggle");
      run_op(1, 2'd1, 12'h3B1, 8'h00, 8'hFF, 0,    1, 0,  0, ST_SUSP,  "R6 suspended sector");
      run_op(0, 2'd0, 12'h555, 8'h80, 8'h81, 2,    0, 0,  0, ST_VFAIL, "R9 verify mismatch");
      run_op(0, 2'd2, 12'h666, 8'h5A, 8'h5A, 0,    0, 40, 0, ST_OK,    "R7 ready pin");
      run_op(1, 2'd3, 12'h777, 8'h00, 8'hFF, 0,    0, 25, 0, ST_OK,    "R7 ready pin alt code");
      run_op(0, 2'd2, 12'h888, 8'h11, 8'h11, 0,    0, -1, 0, ST_TMO,   "R10 ready timeout");
      run_op(0, 2'd0, 12'h999, 8'hC3, 8'hC3, 1000, 0, 0,  0, ST_TMO,   "R10 data poll timeout");

      repeat (20) @(negedge clk);
      chk(sb_q.size() == 0, "R11 scoreboard drained", sb_q.size(), 0);
      chk(busy_o == 0, "R11 idle at end", int'(busy_o), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule